// File: doc/BRIEF.md
# Time Slot Interchange Switch Core

This block moves 8-bit time slots between four serial receive lines and four serial transmit lines. Each line carries a frame of 32 channels, one bit per clock, most significant bit first. A one-cycle `frame_sync` pulse marks bit 0 of channel 0. Every receive line is shifted into a byte register. When the last bit of a channel arrives, the byte is written into a data memory indexed by stream and channel.

Each output slot (stream, channel) has a connection entry made of two parts. The low byte holds either a source address or a literal byte. The control part holds a source-select flag and an output-enable flag. One channel before a slot is transmitted, the core reads that slot's entry and loads the chosen byte into the transmit shift register: either the data memory byte at the addressed source, or the literal byte. It also latches a per-channel enable at the same moment.

A global `proc_all` input forces every slot to send its literal byte and to be enabled. A master `master_oe` input, when low, turns every transmit enable off at once. Tri-state is modelled as the `tx_oe` enable, and `tx_bits` reads 0 whenever its enable is low. Connection entries are written through a simple one-cycle write port.

Top module: `tsi_switch_core`

## Requirements
- R1: After reset every control entry is cleared, so with `proc_all` low every `tx_oe` bit and every `tx_bits` bit stays 0 until entries are programmed.
- R2: In address mode, low-byte bits 6:5 select the source stream and bits 4:0 the source channel; bit 7 is ignored. Output channel c of a stream occupies clock cycles 8c..8c+7 after `frame_sync`, most significant bit first.
- R3: Receive bits are taken most significant bit first. The bit sampled in the cycle of `frame_sync` is bit 7 of channel 0, and a channel's byte is stored once all 8 bits have arrived.
- R4: A source byte received in slot k of a frame can appear on an output no earlier than slot k+2 of that frame. Output slots k and k+1 that address source channel k carry the byte from the previous frame.
- R5: When the source-select flag (control bit 2) of an entry is 1, the low byte itself is transmitted in that slot every frame.
- R6: When the enable flag (control bit 0) of an entry is 0, the slot's `tx_oe` is 0 and `tx_bits` is 0 for all 8 bits; when it is 1, the slot is driven. The enable is constant within a slot.
- R7: With `proc_all` high, every slot transmits its low byte and is enabled, whatever its stored control bits are.
- R8: With `master_oe` low, every `tx_oe` and `tx_bits` bit is 0, regardless of the entries or of `proc_all`.
- R9: One source channel may be addressed by any number of output slots, and every one of them carries the same byte.
- R10: A write with `cfg_we` high stores into the entry (`cfg_strm`, `cfg_chan`). With `cfg_high` = 1 it stores data bits 2 and 0 as the source-select and enable flags. With `cfg_high` = 0 it stores all 8 bits as the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | High in the cycle of bit 0, channel 0 |
| rx_bits | input | 4 | One serial receive bit per stream |
| cfg_we | input | 1 | Connection entry write strobe |
| cfg_high | input | 1 | 1 writes control flags, 0 writes low byte |
| cfg_strm | input | 2 | Output stream of the entry written |
| cfg_chan | input | 5 | Output channel of the entry written |
| cfg_wdata | input | 8 | Write data |
| proc_all | input | 1 | Global literal-and-enable override |
| master_oe | input | 1 | Master transmit enable; low disables all |
| tx_bits | output | 4 | One serial transmit bit per stream |
| tx_oe | output | 4 | Per-stream drive enable for the current bit |

## Verification
A wrong stored data byte or connection entry does not fail quietly. It shows up as a wrong byte in exactly the slots that read it, within one frame of 256 cycles. The bench therefore sweeps every slot of every stream over two settled frames, under several connection patterns. A timing slip in the frame counter or in the fetch point shifts every byte by a bit or a slot. Such a slip shows on the ports within one slot of 8 cycles. The bench rebuilds each expected byte from the source slot's frame and channel, so a fetch one slot too early or too late breaks the two-slot delay boundary at once.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int unsigned TSI_STREAMS = 4;
    localparam int unsigned TSI_CHANS   = 32;
    localparam int unsigned TSI_BITS    = 8;
    // positions of the flags inside the control write word
    localparam int unsigned CTL_SRC_BIT = 2;
    localparam int unsigned CTL_EN_BIT  = 0;
endpackage

// File: rtl/tsi_timebase.sv
module tsi_timebase
    import tsi_pkg::*;
#(
    parameter  int N_CHAN = TSI_CHANS,
    parameter  int W      = TSI_BITS,
    localparam int CW     = $clog2(N_CHAN),
    localparam int BW     = $clog2(W),
    localparam int PW     = CW + BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_sync,
    output logic [CW-1:0] cur_chan,
    output logic [CW-1:0] next_chan,
    output logic          last_bit
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } tb_state_t;

    tb_state_t s_d, s_q;
    logic [PW-1:0] pos;

    always_comb begin
        s_d       = s_q;
        pos       = frame_sync ? '0 : s_q.cnt;
        s_d.cnt   = pos + PW'(1);
        cur_chan  = pos[PW-1:BW];
        next_chan = cur_chan + CW'(1);
        last_bit  = &pos[BW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3
    frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> s_q.cnt == PW'(1));
endmodule

// File: rtl/tsi_rx_capture.sv
module tsi_rx_capture
    import tsi_pkg::*;
#(
    parameter  int N_STRM = TSI_STREAMS,
    parameter  int N_CHAN = TSI_CHANS,
    parameter  int W      = TSI_BITS,
    localparam int SW     = $clog2(N_STRM),
    localparam int CW     = $clog2(N_CHAN)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_STRM-1:0]            rx_bits,
    input  logic [CW-1:0]                cur_chan,
    input  logic                         last_bit,
    input  logic [N_STRM-1:0][SW-1:0]    rd_strm,
    input  logic [N_STRM-1:0][CW-1:0]    rd_chan,
    output logic [N_STRM-1:0][W-1:0]     rd_data
);
    typedef struct packed {
        logic [N_STRM-1:0][W-2:0]             sr;
        logic [N_STRM-1:0][N_CHAN-1:0][W-1:0] mem;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic [N_STRM-1:0][W-1:0] full_byte;

    always_comb begin
        s_d = s_q;
        for (int s = 0; s < N_STRM; s++) begin
            full_byte[s] = {s_q.sr[s], rx_bits[s]};
            s_d.sr[s]    = full_byte[s][W-2:0];
            if (last_bit) s_d.mem[s][cur_chan] = full_byte[s];
        end
        for (int r = 0; r < N_STRM; r++) begin
            rd_data[r] = s_q.mem[rd_strm[r]][rd_chan[r]];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < N_STRM; g++) begin : g_chk
        // R3
        byte_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            last_bit |=> s_q.mem[g][$past(cur_chan)] == $past(full_byte[g]));
    end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
    import tsi_pkg::*;
#(
    parameter  int N_STRM = TSI_STREAMS,
    parameter  int N_CHAN = TSI_CHANS,
    parameter  int W      = TSI_BITS,
    localparam int SW     = $clog2(N_STRM),
    localparam int CW     = $clog2(N_CHAN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic                     cfg_high,
    input  logic [SW-1:0]            cfg_strm,
    input  logic [CW-1:0]            cfg_chan,
    input  logic [W-1:0]             cfg_wdata,
    input  logic [CW-1:0]            rd_chan,
    output logic [N_STRM-1:0][W-1:0] lo_vec,
    output logic [N_STRM-1:0]        src_vec,
    output logic [N_STRM-1:0]        en_vec
);
    typedef struct packed {
        logic [N_STRM-1:0][N_CHAN-1:0][W-1:0] lo;
        logic [N_STRM-1:0][N_CHAN-1:0]        src;
        logic [N_STRM-1:0][N_CHAN-1:0]        en;
    } cm_state_t;

    cm_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cfg_we) begin
            if (cfg_high) begin
                s_d.src[cfg_strm][cfg_chan] = cfg_wdata[CTL_SRC_BIT];
                s_d.en[cfg_strm][cfg_chan]  = cfg_wdata[CTL_EN_BIT];
            end else begin
                s_d.lo[cfg_strm][cfg_chan]  = cfg_wdata;
            end
        end
        for (int s = 0; s < N_STRM; s++) begin
            lo_vec[s]  = s_q.lo[s][rd_chan];
            src_vec[s] = s_q.src[s][rd_chan];
            en_vec[s]  = s_q.en[s][rd_chan];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R10
    low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_high) |=>
            s_q.lo[$past(cfg_strm)][$past(cfg_chan)] == $past(cfg_wdata));

    // R10
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_high) |=>
            s_q.en[$past(cfg_strm)][$past(cfg_chan)] == $past(cfg_wdata[CTL_EN_BIT]));
endmodule

// File: rtl/tsi_tx_engine.sv
module tsi_tx_engine
    import tsi_pkg::*;
#(
    parameter  int N_STRM = TSI_STREAMS,
    parameter  int N_CHAN = TSI_CHANS,
    parameter  int W      = TSI_BITS,
    localparam int SW     = $clog2(N_STRM),
    localparam int CW     = $clog2(N_CHAN)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      last_bit,
    input  logic                      proc_all,
    input  logic                      master_oe,
    input  logic [N_STRM-1:0][W-1:0]  lo_vec,
    input  logic [N_STRM-1:0]         src_vec,
    input  logic [N_STRM-1:0]         en_vec,
    input  logic [N_STRM-1:0][W-1:0]  dm_data,
    output logic [N_STRM-1:0][SW-1:0] dm_strm,
    output logic [N_STRM-1:0][CW-1:0] dm_chan,
    output logic [N_STRM-1:0]         tx_bits,
    output logic [N_STRM-1:0]         tx_oe
);
    typedef struct packed {
        logic [N_STRM-1:0][W-1:0] shreg;
        logic [N_STRM-1:0]        en;
    } tx_state_t;

    tx_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int s = 0; s < N_STRM; s++) begin
            dm_strm[s] = lo_vec[s][CW +: SW];
            dm_chan[s] = lo_vec[s][CW-1:0];
            if (last_bit) begin
                s_d.shreg[s] = (proc_all || src_vec[s]) ? lo_vec[s] : dm_data[s];
                s_d.en[s]    = proc_all || en_vec[s];
            end else begin
                s_d.shreg[s] = {s_q.shreg[s][W-2:0], 1'b0};
            end
            tx_oe[s]   = master_oe && s_q.en[s];
            tx_bits[s] = tx_oe[s] && s_q.shreg[s][W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < N_STRM; g++) begin : g_chk
        // R2
        shift_msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !last_bit |=> s_q.shreg[g] == {$past(s_q.shreg[g][W-2:0]), 1'b0});
        // R6
        en_hold_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !last_bit |=> $stable(s_q.en[g]));
        // R8
        master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !master_oe |-> (tx_oe[g] == 1'b0 && tx_bits[g] == 1'b0));
    end
endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core
    import tsi_pkg::*;
#(
    parameter  int N_STRM = TSI_STREAMS,
    parameter  int N_CHAN = TSI_CHANS,
    parameter  int W      = TSI_BITS,
    localparam int SW     = $clog2(N_STRM),
    localparam int CW     = $clog2(N_CHAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic [N_STRM-1:0] rx_bits,
    input  logic              cfg_we,
    input  logic              cfg_high,
    input  logic [SW-1:0]     cfg_strm,
    input  logic [CW-1:0]     cfg_chan,
    input  logic [W-1:0]      cfg_wdata,
    input  logic              proc_all,
    input  logic              master_oe,
    output logic [N_STRM-1:0] tx_bits,
    output logic [N_STRM-1:0] tx_oe
);
    logic [CW-1:0]                cur_chan, next_chan;
    logic                         last_bit;
    logic [N_STRM-1:0][W-1:0]     lo_vec, dm_data;
    logic [N_STRM-1:0]            src_vec, en_vec;
    logic [N_STRM-1:0][SW-1:0]    dm_strm;
    logic [N_STRM-1:0][CW-1:0]    dm_chan;

    tsi_timebase #(.N_CHAN(N_CHAN), .W(W)) timebase_i (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .cur_chan(cur_chan), .next_chan(next_chan), .last_bit(last_bit)
    );

    tsi_rx_capture #(.N_STRM(N_STRM), .N_CHAN(N_CHAN), .W(W)) rx_i (
        .clk(clk), .rst_n(rst_n), .rx_bits(rx_bits),
        .cur_chan(cur_chan), .last_bit(last_bit),
        .rd_strm(dm_strm), .rd_chan(dm_chan), .rd_data(dm_data)
    );

    tsi_conn_mem #(.N_STRM(N_STRM), .N_CHAN(N_CHAN), .W(W)) cm_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_high(cfg_high),
        .cfg_strm(cfg_strm), .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata),
        .rd_chan(next_chan), .lo_vec(lo_vec), .src_vec(src_vec), .en_vec(en_vec)
    );

    tsi_tx_engine #(.N_STRM(N_STRM), .N_CHAN(N_CHAN), .W(W)) tx_i (
        .clk(clk), .rst_n(rst_n), .last_bit(last_bit),
        .proc_all(proc_all), .master_oe(master_oe),
        .lo_vec(lo_vec), .src_vec(src_vec), .en_vec(en_vec), .dm_data(dm_data),
        .dm_strm(dm_strm), .dm_chan(dm_chan),
        .tx_bits(tx_bits), .tx_oe(tx_oe)
    );
endmodule

// File: tb/tsi_switch_core_tb.sv
module tsi_switch_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic [3:0] rx_bits = '0;
    logic       cfg_we = 1'b0, cfg_high = 1'b0;
    logic [1:0] cfg_strm = '0;
    logic [4:0] cfg_chan = '0;
    logic [7:0] cfg_wdata = '0;
    logic       proc_all = 1'b0, master_oe = 1'b1;
    logic [3:0] tx_bits, tx_oe;

    int errors = 0;
    int checks = 0;

    logic [7:0] m_lo  [4][32];
    logic       m_src [4][32];
    logic       m_en  [4][32];

    always #4 clk = ~clk;

    tsi_switch_core dut_i (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rx_bits(rx_bits),
        .cfg_we(cfg_we), .cfg_high(cfg_high), .cfg_strm(cfg_strm),
        .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata), .proc_all(proc_all),
        .master_oe(master_oe), .tx_bits(tx_bits), .tx_oe(tx_oe)
    );

    function automatic logic [7:0] dat(int ph, int f, int s, int c);
        return 8'((ph * 71 + f * 29 + s * 53 + c * 11 + 1) & 255);
    endfunction

    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual oe/byte=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic program_cfg(int id);
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 32; c++) begin
                if (id == 1) begin
                    m_lo[s][c]  = {c[0], 2'((s + 1) % 4), 5'((c * 3 + s) % 32)};
                    m_src[s][c] = 1'b0;
                    m_en[s][c]  = (c % 5) != 4;
                end else begin
                    if (s == 2) begin
                        m_lo[s][c]  = 8'h05;
                        m_src[s][c] = 1'b0;
                    end else if (c % 3 == 0) begin
                        m_lo[s][c]  = 8'((c * 7 + s * 50) & 255);
                        m_src[s][c] = 1'b1;
                    end else begin
                        m_lo[s][c]  = {1'b0, 2'(3 - s), 5'(31 - c)};
                        m_src[s][c] = 1'b0;
                    end
                    m_en[s][c] = !(s == 3 && c == 10);
                end
                @(negedge clk);
                cfg_we = 1'b1; cfg_high = 1'b1;
                cfg_strm = 2'(s); cfg_chan = 5'(c);
                cfg_wdata = {5'b0, m_src[s][c], 1'b0, m_en[s][c]};
                @(negedge clk);
                cfg_high = 1'b0; cfg_wdata = m_lo[s][c];
            end
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_phase(int ph, int cfg_id);
        logic [7:0] obs [4];
        for (int f = 0; f < 4; f++) begin
            for (int p = 0; p < 256; p++) begin
                int c = p / 8;
                int b = p % 8;
                @(negedge clk);
                for (int s = 0; s < 4; s++) obs[s][3'(7 - b)] = tx_bits[s];
                if (b == 7 && f >= 2) begin
                    for (int s = 0; s < 4; s++) begin
                        logic [7:0] lo = m_lo[s][c];
                        logic       lit = proc_all || m_src[s][c];
                        logic       en = master_oe && (proc_all || m_en[s][c]);
                        logic [7:0] byt;
                        string      tag;
                        int st = int'(lo[6:5]);
                        int sc = int'(lo[4:0]);
                        int a  = f * 32 + c;
                        int bb = a - 2 - ((a - 2 - sc) % 32);
                        byt = lit ? lo : dat(ph, bb / 32, st, sc);
                        if (!master_oe)                      tag = "R8";
                        else if (proc_all)                   tag = "R7";
                        else if (!m_en[s][c])                tag = "R6";
                        else if (m_src[s][c])                tag = "R5";
                        else if (cfg_id == 2 && s == 2)      tag = "R9";
                        else if (((c - sc + 32) % 32) < 2)   tag = "R4";
                        else                                 tag = "R2 R3 R10";
                        check(tag, {tx_oe[s], en ? obs[s] : 8'h00}, {en, en ? byt : 8'h00});
                    end
                end
                frame_sync = (p == 0);
                for (int s = 0; s < 4; s++) begin
                    logic [7:0] d = dat(ph, f, s, c);
                    rx_bits[s] = d[3'(7 - b)];
                end
            end
        end
        @(negedge clk);
        frame_sync = 1'b0;
        rx_bits = '0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: nothing programmed, all outputs off
        repeat (300) @(negedge clk);
        check("R1", {5'b0, tx_oe}, 9'h0);
        check("R1", {5'b0, tx_bits}, 9'h0);
        program_cfg(1);
        run_phase(1, 1);
        program_cfg(2);
        run_phase(2, 2);
        proc_all = 1'b1;
        run_phase(3, 2);
        proc_all = 1'b0;
        master_oe = 1'b0;
        run_phase(4, 2);
        master_oe = 1'b1;
        run_phase(5, 2);
        finish_run();
    end
endmodule